// File: doc/BRIEF.md
# Triggered DMA Channel

This block is a single DMA channel that moves one data item per hardware trigger. Software loads a source address, a destination address, a transfer count, an item size and an address-update mode for each side, then sets the enable bit. Each accepted trigger makes the channel read one item from the source address and then write it to the destination address, using a plain request/ready bus master port.

After every completed write, the channel moves each address by the item size, or leaves it where it is, according to that side's mode. It then lowers the count by one. A trigger that arrives while the channel is busy is held in a pending flag, which software can read and can cancel. Configuration cannot be changed while the channel is enabled or busy. When the count reaches zero the channel disables itself and raises a sticky completion interrupt.

Top module: `trig_dma_channel`

## Requirements
- R1: After reset the enable bit, the pending flag and the done flag are 0, every configuration register reads 0, `bus_req` is low and `irq_done` is low.
- R2: While enable is 1 or a transfer is in progress, writes to source (index 0), destination (1), count (2) and mode (3) are ignored.
- R3: While enable is 0, `trig_in` does not set the pending flag and no bus transfer starts.
- R4: `trig_in` high while enabled sets the pending flag (index 5, bit 0). When the channel is idle, enabled and the flag is set, the flag clears in the cycle the transfer starts. Further triggers that arrive before the start merge into the one flag. A trigger in the start cycle leaves the flag set.
- R5: Writing 1 to bit 0 of index 5 clears a pending flag, so the transfer it stood for never happens.
- R6: A transfer is a read (`bus_req`=1, `bus_we`=0, source address), then a write (`bus_we`=1, destination address, the captured read data). Each phase holds its request and address until a cycle with `bus_ready` high.
- R7: Mode field (source at bits 5:4, destination at bits 9:8 of index 3): 00 keeps the address, 01 subtracts the step, 10 and 11 add the step. The update happens after each completed write.
- R8: The step is 1, 2 or 4 bytes for size code (bits 1:0 of index 3) 0, 1 or 2. Size code 3 means 4 bytes. The same code is driven on `bus_size`.
- R9: The count (index 2, 24 bits) drops by one per completed write. On reaching zero, the enable bit (index 4, bit 0) clears, and later triggers cause no transfer.
- R10: The done flag (index 6, bit 0, also `irq_done`) sets only on the write that brings the count to zero. It stays set until software writes 1 to it.
- R11: Writing 1 to enable while the count is zero leaves enable at 0.
- R12: Updated addresses are never restored. Re-enabling without rewriting them continues from where the last transfer left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 mode, 4 enable, 5 pending flag, 6 done |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the indexed register (index 7 reads 0) |
| trig_in | input | 1 | Trigger event, one per high cycle |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for the write phase, 0 for the read phase |
| bus_addr | output | 32 | Byte address of the current phase |
| bus_size | output | 2 | Item size code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, taken in the ready cycle of the read phase |
| bus_ready | input | 1 | Phase completes in a cycle where this and bus_req are high |
| irq_done | output | 1 | Sticky completion interrupt |

## Verification
A corrupted address register shows at the ports on the very next bus phase, as a wrong `bus_addr`. A corrupted count shows when enable drops and `irq_done` rises a transfer too early or too late. A lost or duplicated pending trigger shows as one bus transfer too few or too many. A stuck phase state shows as `bus_req` or `bus_we` that no longer follows the ready handshake. Since the reference model is compared every cycle, each of these faults is reported within the cycle it first reaches a port or a register read.

// File: rtl/trig_dma_channel.sv
module trig_dma_channel #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          trig_in,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          irq_done
);
  localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_CNT = 3'd2, A_MODE = 3'd3,
                         A_EN = 3'd4, A_FLAG = 3'd5, A_DONE = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st_q;
  logic [AW-1:0] src_q, dst_q, step;
  logic [CW-1:0] cnt_q;
  logic [1:0]    size_q, smode_q, dmode_q;
  logic          en_q, flag_q, done_q;
  logic [DW-1:0] data_q;
  logic          unused_bits;

  wire locked  = en_q || (st_q != S_IDLE);
  wire cfg_ok  = cfg_we && !locked;
  wire start   = (st_q == S_IDLE) && en_q && flag_q;
  wire rd_done = (st_q == S_RD) && bus_ready;
  wire wr_done = (st_q == S_WR) && bus_ready;
  wire last    = wr_done && (cnt_q == CW'(1));

  assign unused_bits = ^cfg_wdata;

  assign step = {{(AW-3){1'b0}}, (size_q == 2'd0) ? 3'd1 : (size_q == 2'd1) ? 3'd2 : 3'd4};

  function automatic logic [AW-1:0] moved(input logic [AW-1:0] a, input logic [1:0] m,
                                          input logic [AW-1:0] s);
    case (m)
      2'b00:   moved = a;
      2'b01:   moved = a - s;
      default: moved = a + s;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      data_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) st_q <= S_RD;
        S_RD: if (bus_ready) begin
          data_q <= bus_rdata;
          st_q <= S_WR;
        end
        default: if (bus_ready) st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      size_q <= '0;
      smode_q <= '0;
      dmode_q <= '0;
    end else if (wr_done) begin
      src_q <= moved(src_q, smode_q, step);
      dst_q <= moved(dst_q, dmode_q, step);
      cnt_q <= cnt_q - CW'(1);
    end else if (cfg_ok) begin
      case (cfg_addr)
        A_SRC: src_q <= cfg_wdata[AW-1:0];
        A_DST: dst_q <= cfg_wdata[AW-1:0];
        A_CNT: cnt_q <= cfg_wdata[CW-1:0];
        A_MODE: begin
          size_q  <= cfg_wdata[1:0];
          smode_q <= cfg_wdata[5:4];
          dmode_q <= cfg_wdata[9:8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      flag_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (last) en_q <= 1'b0;
      else if (cfg_we && cfg_addr == A_EN) en_q <= cfg_wdata[0] && (cnt_q != '0);

      if (trig_in && en_q) flag_q <= 1'b1;
      else if (start || (cfg_we && cfg_addr == A_FLAG && cfg_wdata[0])) flag_q <= 1'b0;

      if (last) done_q <= 1'b1;
      else if (cfg_we && cfg_addr == A_DONE && cfg_wdata[0]) done_q <= 1'b0;
    end
  end

  always_comb begin
    case (cfg_addr)
      A_SRC:   cfg_rdata = DW'(src_q);
      A_DST:   cfg_rdata = DW'(dst_q);
      A_CNT:   cfg_rdata = DW'(cnt_q);
      A_MODE:  cfg_rdata = DW'({dmode_q, 2'b00, smode_q, 2'b00, size_q});
      A_EN:    cfg_rdata = DW'(en_q);
      A_FLAG:  cfg_rdata = DW'(flag_q);
      A_DONE:  cfg_rdata = DW'(done_q);
      default: cfg_rdata = '0;
    endcase
  end

  assign bus_req   = st_q != S_IDLE;
  assign bus_we    = st_q == S_WR;
  assign bus_addr  = (st_q == S_WR) ? dst_q : src_q;
  assign bus_size  = size_q;
  assign bus_wdata = data_q;
  assign irq_done  = done_q;

  // R2
  src_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && st_q == S_IDLE && cfg_we && cfg_addr == A_SRC) |=> $stable(src_q));

  // R4
  flag_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !trig_in) |=> !flag_q);

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R6
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ready) |=> (bus_req && bus_we));

  // R9
  self_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!en_q && cnt_q == '0));

  // R10
  done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (cnt_q == '0));

  // R3
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !bus_req) |=> !bus_req);
endmodule

// File: tb/tb_trig_dma_channel.sv
module tb_trig_dma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        trig_in = 1'b0;
  logic        bus_req, bus_we, irq_done;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        bus_ready = 1'b1;

  int checks = 0, fails = 0, cycn = 0, xfers = 0, wd = 0;
  int rdy_mode = 0;
  bit hold = 0;

  longint m_src, m_dst, m_cnt, m_data;
  int m_size, m_smode, m_dmode, m_st;
  bit m_en, m_flag, m_done;

  always #2 clk = ~clk;

  function automatic logic [31:0] rdat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  assign bus_rdata = rdat(bus_addr);

  trig_dma_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_in(trig_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .irq_done(irq_done)
  );

  function automatic longint stepv(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic longint mv(input longint a, input int m, input int sz);
    if (m == 0) return a;
    if (m == 1) return (a - stepv(sz)) & 64'hFFFFFFFF;
    return (a + stepv(sz)) & 64'hFFFFFFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_cnt = 0; m_data = 0;
      m_size = 0; m_smode = 0; m_dmode = 0; m_st = 0;
      m_en = 0; m_flag = 0; m_done = 0;
    end else begin
      bit busy, go, rdok, wrok, fin, en_o;
      busy = m_en || (m_st != 0);
      go   = (m_st == 0) && m_en && m_flag;
      rdok = (m_st == 1) && bus_ready;
      wrok = (m_st == 2) && bus_ready;
      fin  = wrok && (m_cnt == 1);
      en_o = m_en;
      if (rdok) m_data = rdat(m_src[31:0]);
      if (wrok) begin
        xfers++;
        m_src = mv(m_src, m_smode, m_size);
        m_dst = mv(m_dst, m_dmode, m_size);
        m_cnt = m_cnt - 1;
      end else if (cfg_we && !busy) begin
        if (cfg_addr == 0) m_src = cfg_wdata;
        if (cfg_addr == 1) m_dst = cfg_wdata;
        if (cfg_addr == 2) m_cnt = cfg_wdata[23:0];
        if (cfg_addr == 3) begin
          m_size = cfg_wdata[1:0]; m_smode = cfg_wdata[5:4]; m_dmode = cfg_wdata[9:8];
        end
      end
      if (fin) m_en = 0;
      else if (cfg_we && cfg_addr == 4) m_en = cfg_wdata[0] && (m_cnt != 0 || wrok);
      if (trig_in && en_o) m_flag = 1;
      else if (go || (cfg_we && cfg_addr == 5 && cfg_wdata[0])) m_flag = 0;
      if (fin) m_done = 1;
      else if (cfg_we && cfg_addr == 6 && cfg_wdata[0]) m_done = 0;
      if (m_st == 0) begin if (go) m_st = 1; end
      else if (m_st == 1) begin if (bus_ready) m_st = 2; end
      else if (bus_ready) m_st = 0;
    end
  end

  function automatic logic [31:0] expread(input logic [2:0] a);
    case (a)
      3'd0: return m_src[31:0];
      3'd1: return m_dst[31:0];
      3'd2: return m_cnt[31:0];
      3'd3: return 32'(m_size) | (32'(m_smode) << 4) | (32'(m_dmode) << 8);
      3'd4: return 32'(m_en);
      3'd5: return 32'(m_flag);
      3'd6: return 32'(m_done);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycn, act, exp);
    end
  endtask

  task automatic compare();
    chk("R6 bus_req", 32'(bus_req), 32'(m_st != 0));
    chk("R6 bus_we", 32'(bus_we), 32'(m_st == 2));
    if (m_st != 0) chk("R7 bus_addr", bus_addr, (m_st == 2) ? m_dst[31:0] : m_src[31:0]);
    if (m_st == 2) chk("R6 bus_wdata", bus_wdata, m_data[31:0]);
    chk("R8 bus_size", 32'(bus_size), 32'(m_size));
    chk("R10 irq_done", 32'(irq_done), 32'(m_done));
    chk((cfg_addr == 5) ? "R4 flag read" : (cfg_addr == 2 || cfg_addr == 4) ? "R9 read" : "R7 read",
        cfg_rdata, expread(cfg_addr));
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) compare();
    cycn++;
    case (rdy_mode)
      0: bus_ready = 1'b1;
      1: bus_ready = (cycn % 3) != 0;
      default: bus_ready = 1'b0;
    endcase
    if (!hold && !cfg_we) cfg_addr = cfg_addr + 3'd1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    hold = 1; cfg_addr = a;
    cyc();
    v = cfg_rdata;
    hold = 0;
  endtask

  task automatic pulse();
    trig_in = 1'b1; cyc(); trig_in = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && (m_st != 0 || (m_flag && m_en)); i++) cyc();
    cyc();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", wd);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int x0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 irq_done", 32'(irq_done), 0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end

    // R7 R8 increment source, decrement destination, 4-byte items
    rdy_mode = 1;
    wr(0, 32'h1000); wr(1, 32'h2000); wr(2, 3); wr(3, 32'h122);
    wr(4, 1);
    pulse(); wait_idle();
    chk("R10 no irq before zero", 32'(irq_done), 0);
    pulse(); wait_idle();
    pulse(); wait_idle();
    rd(0, v); chk("R7 R8 src inc", v, 32'h100C);
    rd(1, v); chk("R7 R8 dst dec", v, 32'h1FF4);
    rd(4, v); chk("R9 enable cleared", v, 0);
    chk("R10 irq at zero", 32'(irq_done), 1);
    wr(6, 1); cyc();
    chk("R10 irq cleared by write", 32'(irq_done), 0);

    // R2 R4 locking and trigger merging, 2-byte items
    rdy_mode = 0;
    wr(0, 32'h3000); wr(1, 32'h4000); wr(2, 5); wr(3, 32'h201);
    wr(4, 1);
    wr(0, 32'hDEAD0000);
    rd(0, v); chk("R2 src locked", v, 32'h3000);
    wr(2, 9);
    rd(2, v); chk("R2 count locked", v, 5);
    x0 = xfers;
    rdy_mode = 2;
    pulse(); cyc(); cyc();
    pulse(); cyc(); pulse(); pulse();
    rd(5, v); chk("R4 merged pending flag", v, 1);
    rdy_mode = 0;
    wait_idle();
    chk("R4 merged transfers", 32'(xfers - x0), 2);
    rd(2, v); chk("R9 count", v, 3);
    rd(0, v); chk("R7 fixed src", v, 32'h3000);
    rd(1, v); chk("R8 2-byte step", v, 32'h4004);

    // R5 cancel a pending trigger
    wr(4, 0); cyc();
    wr(2, 4); wr(4, 1);
    x0 = xfers;
    rdy_mode = 2;
    pulse(); cyc(); cyc();
    pulse(); cyc();
    rd(5, v); chk("R4 queued while busy", v, 1);
    wr(5, 1);
    rd(5, v); chk("R5 flag cleared", v, 0);
    rdy_mode = 1;
    wait_idle(); repeat (4) cyc();
    chk("R5 one transfer only", 32'(xfers - x0), 1);
    rd(2, v); chk("R5 count", v, 3);

    // R7 R8 R9 mode 11 and byte items
    rdy_mode = 0;
    wr(4, 0); cyc();
    wr(0, 32'h10); wr(1, 32'h20); wr(3, 32'h030); wr(2, 2);
    wr(4, 1);
    pulse(); wait_idle(); pulse(); wait_idle();
    rd(0, v); chk("R7 mode 11 increments", v, 32'h12);
    rd(1, v); chk("R7 fixed dst", v, 32'h20);
    rd(4, v); chk("R9 self disable", v, 0);
    chk("R10 done", 32'(irq_done), 1);
    x0 = xfers;
    pulse(); repeat (6) cyc();
    chk("R9 trigger after zero ignored", 32'(xfers - x0), 0);
    rd(5, v); chk("R3 flag stays clear", v, 0);
    chk("R3 no request", 32'(bus_req), 0);

    // R12 continue from updated addresses
    wr(2, 1); wr(4, 1);
    pulse(); wait_idle();
    rd(0, v); chk("R12 src not restored", v, 32'h13);

    // R11 enable with zero count
    wr(4, 1);
    rd(4, v); chk("R11 enable refused", v, 0);

    // R3 triggers while disabled
    x0 = xfers;
    pulse(); pulse(); repeat (5) cyc();
    chk("R3 no transfer", 32'(xfers - x0), 0);
    rd(5, v); chk("R3 flag clear", v, 0);

    finish_run();
  end
endmodule